// File: doc/BRIEF.md
# Master-Clock Phase and Time-Slot Generator

This block turns one master clock into the timing of a small processor system. It produces a pixel-rate enable at half the master rate and two non-overlapping processor phase clocks at one quarter of the master rate. It also runs a four-slot sequencer in which each group of four slots forms one microcycle. All outputs are registered flops in the master-clock domain. A downstream consumer uses the phases and slot lines as enables, not as gated clocks.

The sequencer is a nine-state machine. The idle state is ST_IDLE and is held during reset. Eight running states follow, two for each slot: a "high" state in which the slot's phase is asserted and a "gap" state that forms the dead band. The running states are ST_S1_HI, ST_S1_GAP, ST_S2_HI, ST_S2_GAP, ST_S3_HI, ST_S3_GAP, ST_S4_HI and ST_S4_GAP. The transitions are:
- ST_IDLE to ST_S1_HI on the first edge without reset.
- Each state to the next state in that list.
- ST_S4_GAP back to ST_S1_HI, which wraps the microcycle.
- Any state to ST_IDLE on reset.

Slots 1 and 3 fall on phase-1 pulses and slots 2 and 4 fall on phase-2 pulses. One microcycle is therefore eight master cycles, which is two full phase periods.

Top module: `mclk_slot_gen`

## Requirements
- R1: While `rst` is high at a rising edge, every output is low after that edge.
- R2: On the first edge with `rst` low, the outputs show slot 1 (`ts_o` = 4'b0001), `phi1_o` = 1 and `ustart_o` = 1.
- R3: `phi1_o` and `phi2_o` are never high together. Each pulse lasts exactly one master cycle, and at least one master cycle with both low follows it.
- R4: Each phase is high for one cycle in every four master cycles. `phi2_o` is high two cycles after `phi1_o`, which is a half-period (180 degree) offset.
- R5: `ts_o` is one-hot with bit 0 = slot 1, bit 1 = slot 2, bit 2 = slot 3 and bit 3 = slot 4. Each slot lasts two master cycles, in the order 1, 2, 3, 4, 1.
- R6: `phi1_o` is high only during slot 1 or slot 3, and `phi2_o` is high only during slot 2 or slot 4.
- R7: A microcycle is always exactly eight master cycles, which is two `phi1_o` periods. `ustart_o` pulses for one cycle at the start of every slot 1.
- R8: `pix_en_o` is high on every other master cycle, starting with the first running cycle. It is high whenever a phase is high, and it is high four times per microcycle.
- R9: Asserting `rst` in the middle of a run returns the outputs to all-low, and the next release restarts at slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en_o | output | 1 | Pixel-rate enable, half master rate |
| phi1_o | output | 1 | Processor phase 1, one-cycle pulse |
| phi2_o | output | 1 | Processor phase 2, one-cycle pulse |
| ts_o | output | 4 | One-hot time slot, bit 0 = slot 1 |
| ustart_o | output | 1 | Microcycle start strobe |

## Verification
The assertions cover the behaviours that can be checked from one cycle to the next:
- The phases never overlap, and each phase pulse is followed by a gap.
- Each phase pulse falls only in its own slots.
- The slot lines are one-hot.
- The start strobe coincides with slot 1.
- The pixel enable alternates.
- The slot 4 gap always wraps to slot 1.

Only the bench scenarios can show the absolute schedule. These cover:
- The reset values.
- Which output is high in the very first running cycle.
- The exact eight-cycle microcycle and the four-cycle phase periods.
- The restart at slot 1 after a reset in the middle of a run.

// File: rtl/mclk_slot_pkg.sv
package mclk_slot_pkg;

    localparam int SLOT_COUNT = 4;
    localparam int STATE_W    = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 4'd0,
        ST_S1_HI  = 4'd1,
        ST_S1_GAP = 4'd2,
        ST_S2_HI  = 4'd3,
        ST_S2_GAP = 4'd4,
        ST_S3_HI  = 4'd5,
        ST_S3_GAP = 4'd6,
        ST_S4_HI  = 4'd7,
        ST_S4_GAP = 4'd8
    } seq_state_t;

endpackage

// File: rtl/mclk_slot_seq.sv
module mclk_slot_seq
    import mclk_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output seq_state_t state_o,
    output seq_state_t next_o
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state logic: walk the eight running states in a ring.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = ST_S1_HI;
            ST_S1_HI:  state_d = ST_S1_GAP;
            ST_S1_GAP: state_d = ST_S2_HI;
            ST_S2_HI:  state_d = ST_S2_GAP;
            ST_S2_GAP: state_d = ST_S3_HI;
            ST_S3_HI:  state_d = ST_S3_GAP;
            ST_S3_GAP: state_d = ST_S4_HI;
            ST_S4_HI:  state_d = ST_S4_GAP;
            ST_S4_GAP: state_d = ST_S1_HI;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
    assign next_o  = state_d;

    // R5: the slot 4 gap always wraps to slot 1.
    assert_slot_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_S4_GAP) |=> (state_q == ST_S1_HI));

    // R9: the ring never falls back to idle without a reset.
    assert_no_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/mclk_slot_outreg.sv
module mclk_slot_outreg
    import mclk_slot_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  seq_state_t            next_i,
    output logic                  pix_en_o,
    output logic                  phi1_o,
    output logic                  phi2_o,
    output logic [SLOT_COUNT-1:0] ts_o,
    output logic                  ustart_o
);

    logic                  pix_d;
    logic                  phi1_d;
    logic                  phi2_d;
    logic                  ust_d;
    logic [SLOT_COUNT-1:0] ts_d;

    // Decode the upcoming state so the registered outputs line up with it.
    always_comb begin
        pix_d  = 1'b0;
        phi1_d = 1'b0;
        phi2_d = 1'b0;
        ust_d  = 1'b0;
        ts_d   = '0;
        unique case (next_i)
            ST_IDLE: ;
            ST_S1_HI: begin
                pix_d  = 1'b1;
                phi1_d = 1'b1;
                ust_d  = 1'b1;
                ts_d   = 4'b0001;
            end
            ST_S1_GAP: ts_d = 4'b0001;
            ST_S2_HI: begin
                pix_d  = 1'b1;
                phi2_d = 1'b1;
                ts_d   = 4'b0010;
            end
            ST_S2_GAP: ts_d = 4'b0010;
            ST_S3_HI: begin
                pix_d  = 1'b1;
                phi1_d = 1'b1;
                ts_d   = 4'b0100;
            end
            ST_S3_GAP: ts_d = 4'b0100;
            ST_S4_HI: begin
                pix_d  = 1'b1;
                phi2_d = 1'b1;
                ts_d   = 4'b1000;
            end
            ST_S4_GAP: ts_d = 4'b1000;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_en_o <= 1'b0;
            phi1_o   <= 1'b0;
            phi2_o   <= 1'b0;
            ustart_o <= 1'b0;
            ts_o     <= '0;
        end else begin
            pix_en_o <= pix_d;
            phi1_o   <= phi1_d;
            phi2_o   <= phi2_d;
            ustart_o <= ust_d;
            ts_o     <= ts_d;
        end
    end

    // R8: the pixel enable alternates.
    assert_pix_alternate_R8: assert property (@(posedge clk) disable iff (rst)
        pix_en_o |=> !pix_en_o);

    // R5: the slot lines stay one-hot or all low.
    assert_slot_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ts_o));

endmodule

// File: rtl/mclk_slot_gen.sv
module mclk_slot_gen
    import mclk_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output logic       pix_en_o,
    output logic       phi1_o,
    output logic       phi2_o,
    output logic [3:0] ts_o,
    output logic       ustart_o
);

    seq_state_t state_w;
    seq_state_t next_w;

    mclk_slot_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .state_o (state_w),
        .next_o  (next_w)
    );

    mclk_slot_outreg out_i (
        .clk      (clk),
        .rst      (rst),
        .next_i   (next_w),
        .pix_en_o (pix_en_o),
        .phi1_o   (phi1_o),
        .phi2_o   (phi2_o),
        .ts_o     (ts_o),
        .ustart_o (ustart_o)
    );

    // R3: the phases never overlap.
    assert_phase_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        phi1_o |-> !phi2_o);

    // R3: a dead band follows a phase 1 pulse.
    assert_dead_band1_R3: assert property (@(posedge clk) disable iff (rst)
        phi1_o |=> (!phi1_o && !phi2_o));

    // R3: a dead band follows a phase 2 pulse.
    assert_dead_band2_R3: assert property (@(posedge clk) disable iff (rst)
        phi2_o |=> (!phi1_o && !phi2_o));

    // R6: phase 1 falls only in slot 1 or slot 3.
    assert_phi1_slot_R6: assert property (@(posedge clk) disable iff (rst)
        phi1_o |-> (ts_o[0] || ts_o[2]));

    // R6: phase 2 falls only in slot 2 or slot 4.
    assert_phi2_slot_R6: assert property (@(posedge clk) disable iff (rst)
        phi2_o |-> (ts_o[1] || ts_o[3]));

    // R7: the start strobe marks slot 1 with phase 1 high.
    assert_ustart_slot1_R7: assert property (@(posedge clk) disable iff (rst)
        ustart_o |-> (ts_o[0] && phi1_o));

    // R8: the pixel enable is high whenever a phase is high.
    assert_pix_with_phase_R8: assert property (@(posedge clk) disable iff (rst)
        (phi1_o || phi2_o) |-> pix_en_o);

    // R5: the current state and the slot lines stay consistent.
    assert_state_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (state_w == ST_S1_HI) |-> (ts_o == 4'b0001));

endmodule

// File: tb/mclk_slot_gen_tb_top.sv
`timescale 1ns/1ps
module mclk_slot_gen_tb_top;

    logic       clk;
    logic       rst;
    logic       pix_en_o;
    logic       phi1_o;
    logic       phi2_o;
    logic [3:0] ts_o;
    logic       ustart_o;

    int n_tests;
    int n_fail;
    bit done;

    mclk_slot_gen dut_i (
        .clk      (clk),
        .rst      (rst),
        .pix_en_o (pix_en_o),
        .phi1_o   (phi1_o),
        .phi2_o   (phi2_o),
        .ts_o     (ts_o),
        .ustart_o (ustart_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Check every output against the expected schedule for step k after release.
    task automatic check_step(input string req, input int k);
        int s;
        s = k % 8;
        check(req, "phi1",   {7'd0, phi1_o},   {7'd0, (s == 0 || s == 4)});
        check(req, "phi2",   {7'd0, phi2_o},   {7'd0, (s == 2 || s == 6)});
        check(req, "ts",     {4'd0, ts_o},     {4'd0, 4'(1 << (s / 2))});
        check(req, "ustart", {7'd0, ustart_o}, {7'd0, (s == 0)});
        check(req, "pix",    {7'd0, pix_en_o}, {7'd0, (s % 2 == 0)});
    endtask

    // R1: outputs are low while reset is held.
    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "pix",    {7'd0, pix_en_o}, 8'd0);
        check("R1", "phi1",   {7'd0, phi1_o},   8'd0);
        check("R1", "phi2",   {7'd0, phi2_o},   8'd0);
        check("R1", "ts",     {4'd0, ts_o},     8'd0);
        check("R1", "ustart", {7'd0, ustart_o}, 8'd0);
    endtask

    // R2: the first running cycle is slot 1 with phase 1 and the strobe.
    task automatic t_startup;
        rst = 1'b0;
        @(negedge clk);
        check("R2", "ts",     {4'd0, ts_o},     8'h01);
        check("R2", "phi1",   {7'd0, phi1_o},   8'd1);
        check("R2", "ustart", {7'd0, ustart_o}, 8'd1);
    endtask

    // R3 R4 R5 R6: full schedule check over several microcycles.
    task automatic t_sweep;
        int k0;
        k0 = 0;
        check_step("R5", k0);
        for (int k = 1; k < 40; k++) begin
            @(negedge clk);
            check_step("R4", k);
            check("R3", "overlap", {7'd0, (phi1_o & phi2_o)}, 8'd0);
            check("R6", "phi1slot", {7'd0, (phi1_o & ~(ts_o[0] | ts_o[2]))}, 8'd0);
        end
    endtask

    // R7 R8: count strobes, phase pulses and pixel enables over 80 cycles.
    task automatic t_rates;
        int n_us, n_p1, n_p2, n_px;
        n_us = 0; n_p1 = 0; n_p2 = 0; n_px = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            n_us += ustart_o;
            n_p1 += phi1_o;
            n_p2 += phi2_o;
            n_px += pix_en_o;
        end
        check("R7", "ustart count", 8'(n_us), 8'd10);
        check("R7", "phi1 count",   8'(n_p1), 8'd20);
        check("R4", "phi2 count",   8'(n_p2), 8'd20);
        check("R8", "pix count",    8'(n_px), 8'd40);
    endtask

    // R9: a reset in the middle of a run restarts at slot 1.
    task automatic t_midreset;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9", "ts in reset",   {4'd0, ts_o},   8'd0);
        check("R9", "phi2 in reset", {7'd0, phi2_o}, 8'd0);
        rst = 1'b0;
        @(negedge clk);
        check_step("R9", 0);
        for (int k = 1; k < 10; k++) begin
            @(negedge clk);
            check_step("R9", k);
        end
    endtask

    initial begin
        n_tests = 0;
        n_fail  = 0;
        done    = 1'b0;
        rst     = 1'b1;
        t_reset();
        t_startup();
        t_sweep();
        t_rates();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule